// File: doc/BRIEF.md
# Nested Coherence Enable Control Register

This block turns software requests to switch snoop-based cache coherence on and off into one enable level for the local cache controller. Software issues the requests by writing reserved command bits of an existing processor control register, so no new opcode is needed. Code that touches shared data sets the "enable" bit on entry and sets the "disable" bit on exit.

A plain flip-flop would let one section's disable switch coherence off while another nested or overlapping section still depends on it. The block therefore keeps a nesting counter. Each enable request adds one and each disable request subtracts one. The coherence enable output is high whenever the counter is non-zero. The cache controller samples this output before every cache operation.

The counter never wraps. It sticks at its ceiling and raises a sticky overflow flag, and it refuses to go below zero while raising a sticky underflow flag. A readback word reports the enable level, both flags and the current count.

Top module: `coh_nest_ctrl`

## Requirements
- R1: A write with command bit 0 = 1 and bit 1 = 0 raises the count by one. The count reads back in bits [11:8] from the cycle after the write edge.
- R2: A write with bit 1 = 1 and bit 0 = 0 lowers the count by one when the count is above zero.
- R3: `coh_enable` and readback bit 0 are 0 exactly when the count is zero, and 1 otherwise (1 = broadcasts on, 0 = off).
- R4: The count is left unchanged in three cases: a write with bits 0 and 1 both set (the two requests cancel), a write with neither bit set, and any cycle with `csr_wr_valid` low.
- R5: A disable request while the count is zero leaves the count at zero and sets the sticky underflow flag, which reads back in bit 1.
- R6: An enable request while the count is at its maximum (15 by default) leaves the count there and sets the sticky overflow flag, which reads back in bit 2.
- R7: Both flags hold until a write with bit 2 = 1 clears them. If a new flag event occurs in the same cycle as that clear, the flag stays set.
- R8: After reset the count is zero, coherence is off, both flags are clear and the readback word is all zeros.
- R9: Readback bits 7:3 and 31:12 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_valid | input | 1 | Control register write strobe |
| csr_wr_data | input | 32 | Write data: bit 0 = enable, bit 1 = disable, bit 2 = clear flags |
| csr_rd_data | output | 32 | Readback: bit 0 = enable level, bit 1 = underflow, bit 2 = overflow, [11:8] = count |
| coh_enable | output | 1 | Coherence enable to the cache controller |

## Verification
A wrong nesting count is visible at the ports one cycle after the write that causes it, because the readback count field then differs from the count expected by summing requests. A count that is wrong only in being zero or non-zero also shows at once on `coh_enable`. A count that is off by one while still non-zero stays hidden from the cache controller until a later disable, so the bench compares the full readback word after every cycle. The stimulus walks the counter through zero and through its ceiling, where wrap or saturation faults would appear.

// File: rtl/coh_nest_pkg.sv
package coh_nest_pkg;

  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
  } nest_cmd_t;

  // Next nesting count: opposing requests cancel, ends saturate.
  function automatic int unsigned nest_next(int unsigned cur, logic up,
                                            logic down, int unsigned top);
    if (up && !down && cur != top) return cur + 1;
    if (down && !up && cur != 0) return cur - 1;
    return cur;
  endfunction

  // Sticky flag update: a fresh event beats a clear.
  function automatic logic sticky_next(logic cur, logic evt, logic clr);
    return evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/coh_cmd_decode.sv
module coh_cmd_decode
  import coh_nest_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EN_BIT  = 0,
  parameter int DIS_BIT = 1,
  parameter int CLR_BIT = 2
) (
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output nest_cmd_t         cmd
);
  logic unused_data_bits;
  assign unused_data_bits = ^wr_data;

  always_comb begin
    cmd.inc = wr_valid & wr_data[EN_BIT];
    cmd.dec = wr_valid & wr_data[DIS_BIT];
    cmd.clr = wr_valid & wr_data[CLR_BIT];
  end
endmodule

// File: rtl/coh_nest_counter.sv
module coh_nest_counter
  import coh_nest_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             unf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;
  logic             at_zero;

  assign at_max  = (cnt_q == CNT_MAX);
  assign at_zero = (cnt_q == '0);
  assign ovf_evt = inc & ~dec & at_max;
  assign unf_evt = dec & ~inc & at_zero;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(nest_next(32'(cnt_q), inc, dec, 32'(CNT_MAX)));
  end
endmodule

// File: rtl/coh_sticky_flags.sv
module coh_sticky_flags
  import coh_nest_pkg::*;
#(
  parameter int N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] evt,
  input  logic               clr,
  output logic [N_FLAGS-1:0] flags
);
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= sticky_next(flag_q, evt[i], clr);
    end
    assign flags[i] = flag_q;
  end
endmodule

// File: rtl/coh_readback.sv
module coh_readback #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 4,
  parameter int CNT_LSB = 8,
  parameter int ON_BIT  = 0,
  parameter int UNF_BIT = 1,
  parameter int OVF_BIT = 2
) (
  input  logic              on,
  input  logic              unf,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data                      = '0;
    rd_data[ON_BIT]              = on;
    rd_data[UNF_BIT]             = unf;
    rd_data[OVF_BIT]             = ovf;
    rd_data[CNT_LSB +: CNT_W]    = cnt;
  end
endmodule

// File: rtl/coh_nest_ctrl.sv
module coh_nest_ctrl
  import coh_nest_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 4,
  parameter int CNT_LSB = 8,
  parameter int EN_BIT  = 0,
  parameter int DIS_BIT = 1,
  parameter int CLR_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_valid,
  input  logic [DATA_W-1:0] csr_wr_data,
  output logic [DATA_W-1:0] csr_rd_data,
  output logic              coh_enable
);
  localparam int ON_BIT  = 0;
  localparam int UNF_BIT = 1;
  localparam int OVF_BIT = 2;

  nest_cmd_t        cmd;
  logic             cmd_inc;
  logic             cmd_dec;
  logic             ovf_evt;
  logic             unf_evt;
  logic [CNT_W-1:0] nest_cnt;
  logic [1:0]       flags;
  logic             flag_unf;
  logic             flag_ovf;

  coh_cmd_decode #(
    .DATA_W(DATA_W), .EN_BIT(EN_BIT), .DIS_BIT(DIS_BIT), .CLR_BIT(CLR_BIT)
  ) u_dec (
    .wr_valid(csr_wr_valid),
    .wr_data (csr_wr_data),
    .cmd     (cmd)
  );

  assign cmd_inc = cmd.inc;
  assign cmd_dec = cmd.dec;

  coh_nest_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (cmd_inc),
    .dec    (cmd_dec),
    .cnt    (nest_cnt),
    .ovf_evt(ovf_evt),
    .unf_evt(unf_evt)
  );

  coh_sticky_flags #(.N_FLAGS(2)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  ({ovf_evt, unf_evt}),
    .clr  (cmd.clr),
    .flags(flags)
  );

  assign flag_unf   = flags[0];
  assign flag_ovf   = flags[1];
  assign coh_enable = |nest_cnt;

  coh_readback #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
    .ON_BIT(ON_BIT), .UNF_BIT(UNF_BIT), .OVF_BIT(OVF_BIT)
  ) u_rb (
    .on     (coh_enable),
    .unf    (flag_unf),
    .ovf    (flag_ovf),
    .cnt    (nest_cnt),
    .rd_data(csr_rd_data)
  );
endmodule

// File: rtl/coh_nest_ctrl_chk.sv
module coh_nest_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 4,
  parameter int CNT_LSB = 8,
  parameter int EN_BIT  = 0,
  parameter int DIS_BIT = 1,
  parameter int CLR_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr_valid,
  input logic [DATA_W-1:0] csr_wr_data,
  input logic [DATA_W-1:0] csr_rd_data,
  input logic              coh_enable,
  input logic              ovf_evt,
  input logic              unf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rb_cnt;
  logic             w_en, w_dis, w_clr;
  assign rb_cnt = csr_rd_data[CNT_LSB +: CNT_W];
  assign w_en   = csr_wr_valid & csr_wr_data[EN_BIT];
  assign w_dis  = csr_wr_valid & csr_wr_data[DIS_BIT];
  assign w_clr  = csr_wr_valid & csr_wr_data[CLR_BIT];

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en && !w_dis && rb_cnt != CNT_MAX) |=> rb_cnt == CNT_W'($past(rb_cnt) + 1'b1));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_dis && !w_en && rb_cnt != '0) |=> rb_cnt == CNT_W'($past(rb_cnt) - 1'b1));

  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coh_enable == (rb_cnt != '0));

  p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en == w_dis) |=> $stable(rb_cnt));

  p_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (csr_rd_data[1] && rb_cnt == '0));

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (csr_rd_data[2] && rb_cnt == CNT_MAX));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_data[1] && !w_clr) |=> csr_rd_data[1]);

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_data[7:3] == '0);
endmodule

bind coh_nest_ctrl coh_nest_ctrl_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB),
  .EN_BIT(EN_BIT), .DIS_BIT(DIS_BIT), .CLR_BIT(CLR_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_wr_valid(csr_wr_valid),
  .csr_wr_data (csr_wr_data),
  .csr_rd_data (csr_rd_data),
  .coh_enable  (coh_enable),
  .ovf_evt     (ovf_evt),
  .unf_evt     (unf_evt)
);

// File: tb/coh_nest_ctrl_tb_top.sv
module coh_nest_ctrl_tb_top;
  localparam int CMAX = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_valid = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic [31:0] csr_rd_data;
  logic        coh_enable;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_cnt = 0;
  bit m_unf = 0;
  bit m_ovf = 0;

  logic [31:0] q_rd[$];
  logic        q_coh[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  coh_nest_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr_valid(csr_wr_valid),
    .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
    .coh_enable(coh_enable)
  );

  task automatic check(string tag, logic [31:0] act_rd, logic act_coh,
                       logic [31:0] exp_rd, logic exp_coh);
    n_checks++;
    if (act_rd !== exp_rd || act_coh !== exp_coh) begin
      n_fail++;
      $display("FAIL %s: rd=%h coh=%b expected rd=%h coh=%b",
               tag, act_rd, act_coh, exp_rd, exp_coh);
    end
  endtask

  // Driver: one cycle per call; model computed from the requirements.
  task automatic step(bit valid, logic [31:0] data, string tag);
    bit inc, dec, clr, e_unf, e_ovf;
    @(negedge clk);
    csr_wr_valid = valid;
    csr_wr_data  = data;
    inc = valid && data[0];
    dec = valid && data[1];
    clr = valid && data[2];
    e_unf = dec && !inc && m_cnt == 0;
    e_ovf = inc && !dec && m_cnt == CMAX;
    if (inc && !dec && m_cnt < CMAX) m_cnt++;
    else if (dec && !inc && m_cnt > 0) m_cnt--;
    m_unf = e_unf || (m_unf && !clr);
    m_ovf = e_ovf || (m_ovf && !clr);
    q_rd.push_back({20'h0, 4'(m_cnt), 5'h0, m_ovf, m_unf, m_cnt != 0});
    q_coh.push_back(m_cnt != 0);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares after each edge once results are settled.
  always @(posedge clk) begin
    #2;
    if (q_rd.size() > 0) begin
      logic [31:0] e_rd;
      logic        e_coh;
      string       t;
      e_rd  = q_rd.pop_front();
      e_coh = q_coh.pop_front();
      t     = q_tag.pop_front();
      check(t, csr_rd_data, coh_enable, e_rd, e_coh);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset state", csr_rd_data, coh_enable, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R8 after reset", csr_rd_data, coh_enable, 32'h0, 1'b0);

    step(0, 32'h0000_0001, "R4 strobe low ignored");
    for (int i = 0; i < 3; i++) step(1, 32'h1, "R1 R3 enable nests");
    step(1, 32'hA5A5_0000, "R4 R9 no command bits");
    step(1, 32'h0000_0003, "R4 enable+disable cancel");
    step(0, 32'h0000_0002, "R4 disable with strobe low");
    for (int i = 0; i < 3; i++) step(1, 32'h2, "R2 R3 disable unwinds");
    step(1, 32'h2, "R5 disable at zero");
    step(0, 32'h0, "R7 underflow sticky");
    step(1, 32'h1, "R1 R7 enable keeps underflow");
    step(1, 32'h4, "R7 clear flags");
    for (int i = 0; i < 14; i++) step(1, 32'h1, "R1 climb to ceiling");
    step(1, 32'h1, "R6 enable at ceiling");
    step(1, 32'h3, "R4 cancel at ceiling");
    step(1, 32'h5, "R7 overflow beats clear");
    step(1, 32'h4, "R7 clear overflow");
    step(1, 32'hFFFF_F002, "R2 R9 disable with junk bits");
    for (int i = 0; i < 14; i++) step(1, 32'h2, "R2 R3 drain");
    step(1, 32'h6, "R5 R7 underflow beats clear");
    step(0, 32'h0, "R3 idle at zero");
    @(negedge clk);
    csr_wr_valid = 1'b0;
    while (q_rd.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule